// File: doc/BRIEF.md
# Display Controller Command Parser

This block sits behind the byte receiver of a serial display link. It takes each received byte together with a level that marks the byte as pixel data or as command. Pixel bytes go straight out to the address generator with a one-cycle write strobe. Command bytes feed a small parser. The parser reads an opcode, works out from a fixed per-opcode table how many argument bytes follow (none, one, two or eight), collects them, and applies the finished command.

Only three commands change state. The first sets the column window and the second sets the row window. Both reduce their bounds modulo the panel size and pulse a load strobe so that the address generator restarts at the window start. The third loads the addressing-mode register, whose bit 2 selects row-first increment. Every other known opcode consumes its arguments and has no effect. An unknown opcode produces an error pulse and is treated as a finished command with no arguments. A command that is only partly received stays pending while pixel bytes go through.

Top module: `oled_cmd_parser`

## Requirements
- R1: A byte with `byte_valid_i`=1 and `data_sel_i`=1 gives `pix_we_o`=1 and `pix_data_o` equal to that byte one cycle later. It changes no window or mode output.
- R2: Opcode 0x15 followed by two bytes S and E sets `col_start_o`=S mod 64 and `col_end_o`=E mod 64. It pulses `col_load_o` for one cycle. All of this is visible one cycle after byte E.
- R3: Opcode 0x75 followed by two bytes S and E sets `row_start_o`=S mod 80 and `row_end_o`=E mod 80. It pulses `row_load_o` for one cycle. All of this is visible one cycle after byte E.
- R4: Opcode 0xA0 followed by one byte stores that byte in `remap_o`. `vert_o` equals bit 2 of the stored byte.
- R5: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume one following byte and change nothing. The byte after that one is parsed as an opcode.
- R6: Opcodes 0x84-0x86, 0xA4-0xA7, 0xAE, 0xAF, 0xE3 and 0xFF take no argument. The next command byte is parsed as an opcode.
- R7: Opcode 0xB8 consumes the eight command bytes that follow it, whatever their values, and changes nothing.
- R8: An unknown opcode gives `err_o`=1 for one cycle, one cycle after the byte. The next command byte is parsed as a new opcode.
- R9: Data bytes received between the arguments of a command do not cancel the pending command. Its remaining arguments are still collected.
- R10: While `rst_ni` is low: `col_start_o`=0, `col_end_o`=63, `row_start_o`=0, `row_end_o`=79, `remap_o`=0, and every strobe is 0. No argument is pending after reset.
- R11: A cycle with `byte_valid_i`=0 produces no strobe and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A received byte is present this cycle |
| byte_i | input | 8 | Received byte |
| data_sel_i | input | 1 | 1 = pixel data, 0 = command |
| pix_we_o | output | 1 | Pixel write strobe |
| pix_data_o | output | 8 | Pixel byte |
| col_start_o | output | 6 | Column window start |
| col_end_o | output | 6 | Column window end |
| col_load_o | output | 1 | Load current column from the start value |
| row_start_o | output | 7 | Row window start |
| row_end_o | output | 7 | Row window end |
| row_load_o | output | 1 | Load current row from the start value |
| remap_o | output | 8 | Addressing-mode register |
| vert_o | output | 1 | Row-first increment selected |
| err_o | output | 1 | Unknown opcode pulse |

## Verification
Every result is registered once. A pixel strobe, an error pulse, and a window or mode update with its load strobe all appear in the cycle after the edge that accepts the byte that triggers them. Only the last argument byte of a command triggers anything. The bench drives each byte on a falling edge and takes it away on the next falling edge, then samples. The sample therefore falls half a period after the edge that produced the result and before the next edge can clear a strobe. Checks that a byte had no effect are made at the same point, and again after the following opcode shows how that byte was parsed.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;

  localparam int unsigned MAX_ARGS = 8;
  localparam int unsigned ARG_W    = $clog2(MAX_ARGS + 1);

  localparam logic [7:0] OP_COL_WIN = 8'h15;
  localparam logic [7:0] OP_ROW_WIN = 8'h75;
  localparam logic [7:0] OP_MODE    = 8'hA0;
  localparam logic [7:0] OP_GREY    = 8'hB8;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_COL   = 2'd1,
    K_ROW   = 2'd2,
    K_MODE  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic             known;
    logic [ARG_W-1:0] nargs;
    cmd_kind_e        kind;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [7:0] op);
    op_info_t r;
    r = '{known: 1'b1, nargs: '0, kind: K_NONE};
    case (op)
      OP_COL_WIN: begin r.nargs = ARG_W'(2); r.kind = K_COL; end
      OP_ROW_WIN: begin r.nargs = ARG_W'(2); r.kind = K_ROW; end
      OP_MODE:    begin r.nargs = ARG_W'(1); r.kind = K_MODE; end
      OP_GREY:    r.nargs = ARG_W'(MAX_ARGS);
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                  r.nargs = ARG_W'(1);
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3, 8'hFF:
                  r.nargs = '0;
      default:    r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/oled_op_decode.sv
module oled_op_decode
  import oled_cmd_pkg::*;
(
  input  logic [7:0] op_i,
  output op_info_t   info_o
);
  always_comb info_o = decode_op(op_i);
endmodule

// File: rtl/oled_arg_collect.sv
module oled_arg_collect
  import oled_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output cmd_kind_e  done_kind_o,
  output logic [7:0] first_arg_o,
  output logic [7:0] last_arg_o,
  output logic       err_o
);

  op_info_t         info;
  logic             pend_q, pend_d;
  cmd_kind_e        kind_q, kind_d;
  logic [ARG_W-1:0] need_q, need_d, got_q, got_d;
  logic [7:0]       first_q, first_d;
  logic             err_d;

  oled_op_decode u_dec (.op_i(byte_i), .info_o(info));

  always_comb begin
    pend_d      = pend_q;
    kind_d      = kind_q;
    need_d      = need_q;
    got_d       = got_q;
    first_d     = first_q;
    err_d       = 1'b0;
    done_o      = 1'b0;
    done_kind_o = K_NONE;
    first_arg_o = first_q;
    last_arg_o  = byte_i;
    if (cmd_valid_i) begin
      if (!pend_q) begin
        if (!info.known) begin
          err_d = 1'b1;
        end else if (info.nargs == '0) begin
          done_o      = 1'b1;
          done_kind_o = info.kind;
        end else begin
          pend_d = 1'b1;
          kind_d = info.kind;
          need_d = info.nargs;
          got_d  = '0;
        end
      end else begin
        if (got_q == '0) first_d = byte_i;
        if (got_q == '0) first_arg_o = byte_i;
        got_d = got_q + ARG_W'(1);
        if (got_q + ARG_W'(1) == need_q) begin
          done_o      = 1'b1;
          done_kind_o = kind_q;
          pend_d      = 1'b0;
          got_d       = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      kind_q  <= K_NONE;
      need_q  <= '0;
      got_q   <= '0;
      first_q <= '0;
      err_o   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      kind_q  <= kind_d;
      need_q  <= need_d;
      got_q   <= got_d;
      first_q <= first_d;
      err_o   <= err_d;
    end
  end

  // pending count never reaches the number required (R7)
  assert_arg_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (got_q < need_q) && (need_q <= ARG_W'(MAX_ARGS)));

  // an error pulse never coincides with a pending command start (R8)
  assert_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pend_q);

  // without a command byte, parse state holds (R11)
  assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(pend_q) && $stable(got_q));

endmodule

// File: rtl/oled_win_regs.sv
module oled_win_regs
  import oled_cmd_pkg::*;
#(
  parameter int unsigned NCOL = 64,
  parameter int unsigned NROW = 80,
  localparam int unsigned CW  = $clog2(NCOL),
  localparam int unsigned RW  = $clog2(NROW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  cmd_kind_e     kind_i,
  input  logic [7:0]    first_i,
  input  logic [7:0]    last_i,
  output logic [CW-1:0] col_start_o,
  output logic [CW-1:0] col_end_o,
  output logic          col_load_o,
  output logic [RW-1:0] row_start_o,
  output logic [RW-1:0] row_end_o,
  output logic          row_load_o,
  output logic [7:0]    remap_o
);

  logic [CW-1:0] col_s, col_e;
  logic [RW-1:0] row_s, row_e;
  logic          do_col, do_row, do_mode;

  always_comb begin
    col_s   = CW'(32'(first_i) % NCOL);
    col_e   = CW'(32'(last_i)  % NCOL);
    row_s   = RW'(32'(first_i) % NROW);
    row_e   = RW'(32'(last_i)  % NROW);
    do_col  = done_i && (kind_i == K_COL);
    do_row  = done_i && (kind_i == K_ROW);
    do_mode = done_i && (kind_i == K_MODE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_start_o <= '0;
      col_end_o   <= CW'(NCOL - 1);
      row_start_o <= '0;
      row_end_o   <= RW'(NROW - 1);
      remap_o     <= '0;
      col_load_o  <= 1'b0;
      row_load_o  <= 1'b0;
    end else begin
      col_load_o <= do_col;
      row_load_o <= do_row;
      if (do_col) begin
        col_start_o <= col_s;
        col_end_o   <= col_e;
      end
      if (do_row) begin
        row_start_o <= row_s;
        row_end_o   <= row_e;
      end
      if (do_mode) remap_o <= last_i;
    end
  end

  assert_row_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(row_start_o) < NROW) && (32'(row_end_o) < NROW));

  assert_col_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(col_start_o) < NCOL) && (32'(col_end_o) < NCOL));

  // window moves only alongside its load strobe
  assert_col_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_load_o |-> $stable(col_start_o) || $past(!rst_ni));

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({col_load_o, row_load_o}));

endmodule

// File: rtl/oled_cmd_parser.sv
module oled_cmd_parser
  import oled_cmd_pkg::*;
#(
  parameter int unsigned NCOL = 64,
  parameter int unsigned NROW = 80,
  localparam int unsigned CW  = $clog2(NCOL),
  localparam int unsigned RW  = $clog2(NROW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  input  logic          data_sel_i,
  output logic          pix_we_o,
  output logic [7:0]    pix_data_o,
  output logic [CW-1:0] col_start_o,
  output logic [CW-1:0] col_end_o,
  output logic          col_load_o,
  output logic [RW-1:0] row_start_o,
  output logic [RW-1:0] row_end_o,
  output logic          row_load_o,
  output logic [7:0]    remap_o,
  output logic          vert_o,
  output logic          err_o
);

  localparam int unsigned VERT_BIT = 2;

  logic       cmd_valid, pix_valid;
  logic       done;
  cmd_kind_e  done_kind;
  logic [7:0] first_arg, last_arg;

  assign cmd_valid = byte_valid_i && !data_sel_i;
  assign pix_valid = byte_valid_i && data_sel_i;

  oled_arg_collect u_coll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .byte_i      (byte_i),
    .done_o      (done),
    .done_kind_o (done_kind),
    .first_arg_o (first_arg),
    .last_arg_o  (last_arg),
    .err_o       (err_o)
  );

  oled_win_regs #(.NCOL(NCOL), .NROW(NROW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .kind_i      (done_kind),
    .first_i     (first_arg),
    .last_i      (last_arg),
    .col_start_o (col_start_o),
    .col_end_o   (col_end_o),
    .col_load_o  (col_load_o),
    .row_start_o (row_start_o),
    .row_end_o   (row_end_o),
    .row_load_o  (row_load_o),
    .remap_o     (remap_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_we_o   <= 1'b0;
      pix_data_o <= '0;
    end else begin
      pix_we_o <= pix_valid;
      if (pix_valid) pix_data_o <= byte_i;
    end
  end

  assign vert_o = remap_o[VERT_BIT];

  assert_pix_we_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_o |-> $past(byte_valid_i && data_sel_i));

  assert_pix_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_o |-> pix_data_o == $past(byte_i));

  assert_data_no_cfg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && data_sel_i) |=> !col_load_o && !row_load_o && !err_o);

  assert_err_vs_pix_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pix_we_o);

endmodule

// File: tb/sim_oled_cmd_parser.sv
`timescale 1ns/1ps
module sim_oled_cmd_parser;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_v = '0;
  logic       data_sel = 1'b0;
  logic       pix_we, col_load, row_load, vert, err;
  logic [7:0] pix_data, remap;
  logic [5:0] col_start, col_end;
  logic [6:0] row_start, row_end;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  oled_cmd_parser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid), .byte_i(byte_v),
    .data_sel_i(data_sel), .pix_we_o(pix_we), .pix_data_o(pix_data),
    .col_start_o(col_start), .col_end_o(col_end), .col_load_o(col_load),
    .row_start_o(row_start), .row_end_o(row_end), .row_load_o(row_load),
    .remap_o(remap), .vert_o(vert), .err_o(err)
  );

  // {data_sel, byte, expected pix_we, expected err}
  localparam int NV = 22;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 8'h00, 2'b01},  // R8 unknown
    {1'b0, 8'hE3, 2'b00},  // R6
    {1'b1, 8'h5A, 2'b10},  // R1
    {1'b0, 8'h81, 2'b00},  // R5
    {1'b0, 8'h00, 2'b00},  // R5 argument
    {1'b0, 8'h00, 2'b01},  // R5 next is opcode
    {1'b0, 8'hB8, 2'b00},  // R7
    {1'b0, 8'h00, 2'b00}, {1'b0, 8'h00, 2'b00}, {1'b0, 8'h00, 2'b00},
    {1'b0, 8'h00, 2'b00}, {1'b0, 8'h00, 2'b00}, {1'b0, 8'h00, 2'b00},
    {1'b0, 8'h00, 2'b00}, {1'b0, 8'h00, 2'b00},
    {1'b0, 8'h00, 2'b01},  // R7 ninth byte is opcode
    {1'b0, 8'hFF, 2'b00},  // R6 filler
    {1'b0, 8'h00, 2'b01},  // R6 no arg after filler
    {1'b0, 8'hA8, 2'b00},  // R9
    {1'b1, 8'hC3, 2'b10},  // R9 data mid-command
    {1'b0, 8'h77, 2'b00},  // R9 completes pending
    {1'b0, 8'h77, 2'b01}   // R9 now unknown opcode
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit dsel, input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1; data_sel = dsel; byte_v = b;
    @(negedge clk);
    byte_valid = 1'b0; data_sel = 1'b0;
  endtask

  task automatic chk_reset_vals(input string tag);
    chk(col_start == 0, tag, col_start, 0);
    chk(col_end == 63, tag, col_end, 63);
    chk(row_start == 0, tag, row_start, 0);
    chk(row_end == 79, tag, row_end, 79);
    chk(remap == 0, tag, remap, 0);
    chk(!pix_we && !err && !col_load && !row_load, tag,
        {pix_we, err, col_load, row_load}, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_vals("R10 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][10], VEC[i][9:2]);
      chk(pix_we == VEC[i][1], $sformatf("R1 we vec%0d", i), pix_we, VEC[i][1]);
      chk(err == VEC[i][0], $sformatf("R8 err vec%0d", i), err, VEC[i][0]);
      if (VEC[i][1])
        chk(pix_data == VEC[i][9:2], "R1 pix data", pix_data, VEC[i][9:2]);
    end
    chk(col_start == 0 && col_end == 63 && remap == 0, "R5 no state change",
        {col_start, col_end}, 63);
    chk(row_start == 0 && row_end == 79, "R7 no state change", row_end, 79);

    // R11: idle cycle
    @(negedge clk);
    chk(!pix_we && !err, "R11 idle strobes", {pix_we, err}, 0);

    // R2: column window, modulo 64
    send(1'b0, 8'h15);
    send(1'b0, 8'd70);
    chk(col_start == 0 && !col_load, "R2 before last arg", col_start, 0);
    send(1'b0, 8'd200);
    chk(col_start == 6, "R2 col start", col_start, 6);
    chk(col_end == 8, "R2 col end", col_end, 8);
    chk(col_load == 1'b1, "R2 load pulse", col_load, 1);
    @(negedge clk);
    chk(col_load == 1'b0, "R2 load one cycle", col_load, 0);

    // R3: row window, modulo 80
    send(1'b0, 8'h75);
    send(1'b0, 8'd85);
    send(1'b0, 8'd255);
    chk(row_start == 5, "R3 row start", row_start, 5);
    chk(row_end == 15, "R3 row end", row_end, 15);
    chk(row_load && !col_load, "R3 load pulse", row_load, 1);

    // R4: mode register
    send(1'b0, 8'hA0);
    send(1'b0, 8'h04);
    chk(remap == 8'h04, "R4 remap", remap, 4);
    chk(vert == 1'b1, "R4 vert", vert, 1);
    send(1'b0, 8'hA0);
    send(1'b0, 8'hFB);
    chk(remap == 8'hFB && !vert, "R4 vert clear", {remap, vert}, 16'h1F6);

    // R9: data inside column command
    send(1'b0, 8'h15);
    send(1'b0, 8'd3);
    send(1'b1, 8'h99);
    chk(pix_we && pix_data == 8'h99 && col_start == 6, "R9 data passes",
        pix_data, 8'h99);
    send(1'b0, 8'd9);
    chk(col_start == 3 && col_end == 9, "R9 pending kept", col_start, 3);

    // R10: reset mid-command
    send(1'b0, 8'h75);
    send(1'b0, 8'd1);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk_reset_vals("R10 after reset");
    rst_ni = 1'b1;
    @(negedge clk);
    send(1'b0, 8'd2);
    chk(err == 1'b1, "R10 pending cleared", err, 1);

    finish_run();
  end

endmodule